// File: doc/BRIEF.md
# Bus Timeout and Retry Controller

This block sits between a processor core and its memory bus. It watches every bus operation the core starts and waits for the memory side to return an acknowledge. Memory behind the bus, such as DRAM, may need hundreds of clocks to answer, so the block waits a fixed window of 256 request cycles before it gives up on an attempt.

When an attempt times out, the block drops the request for one clock and then issues the same operation again, with the same address, direction and byte lanes. If four such retries all time out, the block stops retrying. It then sends the core a one-clock exception pulse that carries a cause code and the failing address. A successful operation ends with a one-clock done pulse. The memory devices and the core's exception handling lie outside this block.

Top module: `bus_retry_ctrl`

## Requirements
- R1: A start strobe accepted while the block is idle raises `bus_req_o` in the next cycle. While the request is high, `bus_addr_o`, `bus_we_o` and `bus_sel_o` carry the attributes that were captured with the strobe.
- R2: When `bus_ack_i` is high in a cycle where the request is high, the request drops and `done_o` is high in the following cycle.
- R3: An attempt whose request stays high for 256 cycles without an ack times out, and the request drops after its 256th cycle.
- R4: An ack in the 256th request cycle of an attempt counts as success, not as a timeout.
- R5: After a timeout that still has retries left, the request is low for exactly one cycle. The same operation is then reissued, and its 256-cycle window counts from zero again.
- R6: At most four retries follow the first attempt, so an operation makes at most five attempts. When the fifth attempt times out, `exc_o` pulses in the following cycle with `exc_cause_o` = 8'h21 and `exc_addr_o` equal to the operation's address.
- R7: The retry count starts from zero for every new operation, so an operation that follows an exception again gets four retries.
- R8: A start strobe received while an operation is in progress (request high or in the gap between attempts) is ignored. The operation's attributes on the bus do not change.
- R9: An ack received while no request is outstanding is ignored and produces no done pulse.
- R10: `done_o` and `exc_o` are single-cycle pulses and are never high together. `exc_cause_o` and `exc_addr_o` read zero whenever `exc_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe from the core |
| op_addr_i | input | ADDR_W | Operation address |
| op_we_i | input | 1 | Operation is a write |
| op_sel_i | input | SEL_W | Byte lane enables |
| bus_req_o | output | 1 | Bus request (cycle active) |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_we_o | output | 1 | Bus write enable |
| bus_sel_o | output | SEL_W | Bus byte lane enables |
| bus_ack_i | input | 1 | Acknowledge from memory |
| done_o | output | 1 | Operation completed pulse |
| exc_o | output | 1 | Bus exception pulse |
| exc_cause_o | output | 8 | Exception cause code |
| exc_addr_o | output | ADDR_W | Address of failing operation |

## Verification
The hardest case to reach is the exact edge of the window: an ack that arrives in the 256th request cycle of the fifth and final attempt. The outcome there depends on both the timer and the retry count being at their limits. The bench includes a slave model that counts request cycles and attempts from the bus pins alone. It can be programmed to answer on a chosen attempt and in a chosen cycle, or never to answer. This lets the stimulus reach that cycle directly, and the scoreboard checks the attempt count and the completion cycle.

// File: rtl/bto_pkg.sv
package bto_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } bto_state_e;

    localparam int          CAUSE_W           = 8;
    localparam logic [7:0]  CAUSE_BUS_TIMEOUT = 8'h21;
endpackage

// File: rtl/bto_timer.sv
module bto_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || expired_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R3
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);  // R5
endmodule

// File: rtl/bto_retry_cnt.sv
module bto_retry_cnt #(
    parameter int MAX_RETRY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int RW = $clog2(MAX_RETRY + 1);
    localparam logic [RW-1:0] TOP = RW'(MAX_RETRY);

    logic [RW-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                 cnt_d = '0;
        else if (inc_i && !last_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);  // R6
    AST_RETRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);  // R7
endmodule

// File: rtl/bus_retry_ctrl.sv
module bus_retry_ctrl
    import bto_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 4,
    parameter int TIMEOUT   = 256,
    parameter int MAX_RETRY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  op_addr_i,
    input  logic               op_we_i,
    input  logic [SEL_W-1:0]   op_sel_i,
    output logic               bus_req_o,
    output logic [ADDR_W-1:0]  bus_addr_o,
    output logic               bus_we_o,
    output logic [SEL_W-1:0]   bus_sel_o,
    input  logic               bus_ack_i,
    output logic               done_o,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] exc_cause_o,
    output logic [ADDR_W-1:0]  exc_addr_o
);
    typedef struct packed {
        bto_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic              done;
        logic              exc;
    } ctl_t;

    ctl_t s_d, s_q;
    logic expired, last_try, accept, retry_inc;

    bto_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (s_q.st == ST_REQ),
        .expired_o (expired)
    );

    bto_retry_cnt #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .inc_i  (retry_inc),
        .last_o (last_try)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.exc   = 1'b0;
        accept    = 1'b0;
        retry_inc = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    accept   = 1'b1;
                    s_d.st   = ST_REQ;
                    s_d.addr = op_addr_i;
                    s_d.we   = op_we_i;
                    s_d.sel  = op_sel_i;
                end
            end
            ST_REQ: begin
                if (bus_ack_i) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else if (expired) begin
                    if (last_try) begin
                        s_d.st  = ST_IDLE;
                        s_d.exc = 1'b1;
                    end else begin
                        s_d.st    = ST_GAP;
                        retry_inc = 1'b1;
                    end
                end
            end
            ST_GAP:  s_d.st = ST_REQ;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_req_o   = (s_q.st == ST_REQ);
    assign bus_addr_o  = s_q.addr;
    assign bus_we_o    = s_q.we;
    assign bus_sel_o   = s_q.sel;
    assign done_o      = s_q.done;
    assign exc_o       = s_q.exc;
    assign exc_cause_o = s_q.exc ? CAUSE_BUS_TIMEOUT : '0;
    assign exc_addr_o  = s_q.exc ? s_q.addr : '0;

    AST_ACK_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_ack_i) |=> (done_o && !bus_req_o));  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R10
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |=> !exc_o);  // R10
    AST_NO_DUAL_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && exc_o));  // R10
    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (exc_cause_o == CAUSE_BUS_TIMEOUT));  // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && start_i) |=> $stable(bus_addr_o));  // R8
    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req_o && bus_ack_i) |=> !done_o);  // R9
endmodule

// File: tb/bus_retry_ctrl_tb.sv
module bus_retry_ctrl_tb;
    localparam int TMO = 256;
    localparam int RET = 4;
    localparam int PER = TMO + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] op_addr_i = '0;
    logic        op_we_i = 1'b0;
    logic [3:0]  op_sel_i = '0;
    logic        bus_req_o, bus_we_o, done_o, exc_o;
    logic [31:0] bus_addr_o, exc_addr_o;
    logic [3:0]  bus_sel_o;
    logic        bus_ack_i = 1'b0;
    logic [7:0]  exc_cause_o;

    bus_retry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_addr_i(op_addr_i),
        .op_we_i(op_we_i), .op_sel_i(op_sel_i), .bus_req_o(bus_req_o),
        .bus_addr_o(bus_addr_o), .bus_we_o(bus_we_o), .bus_sel_o(bus_sel_o),
        .bus_ack_i(bus_ack_i), .done_o(done_o), .exc_o(exc_o),
        .exc_cause_o(exc_cause_o), .exc_addr_o(exc_addr_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          is_exc;
        logic [31:0] addr;
        bit          we;
        logic [3:0]  sel;
        int          attempts;
        int          lat;
    } exp_t;

    exp_t expq[$];
    int   nchk = 0, nfail = 0;
    int   cyc = 0, start_cyc = 0;
    int   ack_tgt = 99, ack_dly = 0;
    bit   idle_ack = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slave model and monitor
    int  att = 0, idx = 0;
    bit  prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req_o) begin
                if (!prev_req) begin
                    att++;
                    idx = 0;
                end
                idx++;
                if (expq.size() != 0) begin
                    check(bus_addr_o == expq[0].addr, "R1", "bus address held", bus_addr_o, expq[0].addr);
                    check(bus_we_o == expq[0].we && bus_sel_o == expq[0].sel, "R1", "we/sel held",
                          {bus_we_o, bus_sel_o}, {expq[0].we, expq[0].sel});
                end
                bus_ack_i = (att - 1 == ack_tgt) && (idx == ack_dly);
            end else begin
                bus_ack_i = idle_ack;
            end
            prev_req = bus_req_o;
            if (done_o || exc_o) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9", "unexpected completion pulse", {done_o, exc_o}, 0);
                end else begin
                    exp_t e;
                    int   k;
                    e = expq.pop_front();
                    k = cyc - start_cyc + 1;
                    check(exc_o == e.is_exc && done_o == !e.is_exc, "R10", "completion kind",
                          {done_o, exc_o}, e.is_exc ? 1 : 2);
                    check(att == e.attempts, e.is_exc ? "R6" : "R5", "attempt count", att, e.attempts);
                    check(k == e.lat, e.lat == PER * (RET + 1) ? "R6" : "R3", "completion cycle", k, e.lat);
                    if (e.is_exc) begin
                        check(exc_cause_o == 8'h21, "R6", "cause code", exc_cause_o, 8'h21);
                        check(exc_addr_o == e.addr, "R6", "failing address", exc_addr_o, e.addr);
                    end else begin
                        check(exc_cause_o == 0 && exc_addr_o == 0, "R10", "exception fields idle",
                              {exc_cause_o, exc_addr_o}, 0);
                    end
                    att = 0;
                end
            end
        end
    end

    task automatic run_op(input logic [31:0] a, input bit we, input logic [3:0] sel,
                          input int tgt, input int dly, input bit busy_start);
        exp_t e;
        e.addr = a; e.we = we; e.sel = sel;
        if (tgt <= RET) begin
            e.is_exc = 1'b0; e.attempts = tgt + 1; e.lat = tgt * PER + dly + 1;
        end else begin
            e.is_exc = 1'b1; e.attempts = RET + 1; e.lat = PER * (RET + 1);
        end
        ack_tgt = tgt; ack_dly = dly;
        expq.push_back(e);
        @(negedge clk);
        start_i = 1'b1; op_addr_i = a; op_we_i = we; op_sel_i = sel;
        start_cyc = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        check(bus_req_o == 1'b1, "R1", "request after start", bus_req_o, 1);
        if (busy_start) begin
            repeat (9) @(negedge clk);
            start_i = 1'b1; op_addr_i = 32'hDEAD_0000; op_we_i = ~we; op_sel_i = ~sel;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (expq.size() == 0);
        repeat (3) @(negedge clk);
        check(bus_req_o == 1'b0 && done_o == 1'b0, "R8", "quiet after operation",
              {bus_req_o, done_o}, 0);
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req_o && !done_o && !exc_o, "R10", "reset state",
              {bus_req_o, done_o, exc_o}, 0);
        // R2: immediate ack
        run_op(32'h0000_1000, 1'b0, 4'hF, 0, 1, 1'b0);
        // R2: write, ack mid-window
        run_op(32'h0000_2004, 1'b1, 4'h3, 0, 40, 1'b0);
        // R4: ack in 256th cycle of first attempt
        run_op(32'h0000_3008, 1'b0, 4'h1, 0, TMO, 1'b0);
        // R5: success on third attempt
        run_op(32'h0000_400C, 1'b1, 4'hC, 2, 5, 1'b0);
        // R4 + R6: ack in 256th cycle of fifth attempt
        run_op(32'h0000_5010, 1'b0, 4'hF, RET, TMO, 1'b0);
        // R6: never acked -> exception
        run_op(32'h0000_6014, 1'b1, 4'h8, 99, 0, 1'b0);
        // R7: after exception, full retry budget again
        run_op(32'h0000_7018, 1'b0, 4'h2, RET, 3, 1'b0);
        // R8: start while busy ignored
        run_op(32'h0000_801C, 1'b1, 4'h6, 1, 10, 1'b1);
        // R9: ack with no request outstanding
        idle_ack = 1'b1;
        repeat (4) @(negedge clk);
        idle_ack = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check(!done_o && !exc_o, "R9", "idle ack ignored", {done_o, exc_o}, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule